// File: doc/BRIEF.md
# Short-Frame PCM Serial Port

This block is a full-duplex serial port for 8-bit PCM samples using short frame sync. It runs on one system clock. Each direction's bit clock, frame sync and serial data enter as levels that are already synchronous to that clock. The block finds bit-clock edges by comparing each sample with the one before it, so the bit clock must stay in each phase for at least one system clock.

A frame starts when frame sync is high at a falling bit-clock edge. On the transmit side, that edge loads the word for the slot. The next rising edge enables the output and drives the sign bit, and seven more rising edges send the remaining bits, most significant first. A falling edge then releases the output. While the output is enabled, an open-drain style slot indicator is held low. The word that goes out is the one presented at the previous frame start, which matches a converter that delivers the previous cycle's result.

The receive side latches one bit on each of the eight falling edges that follow its frame-sync edge. It then presents the word with a single-cycle valid strobe. A select input lets the receive side use the transmit bit clock, for operation from one shared clock.

Top module: `pcm_sf_port`

## Requirements
- R1: After reset, tx_oe is 0, tx_slot_n is 1, rx_valid is 0 and rx_word is all zeros.
- R2: A frame starts only when frame sync is 1 at a falling bit-clock edge. A frame-sync pulse that rises and falls while the bit clock is high starts nothing: tx_oe stays 0 through the next rising edge.
- R3: The first rising bit-clock edge after a transmit frame start sets tx_oe to 1 and tx_slot_n to 0, and puts bit 7 (the sign bit) of the loaded word on tx_dout.
- R4: Each of the next seven rising edges puts the next lower bit on tx_dout, ending with bit 0. tx_dout changes only on a rising edge.
- R5: The first falling edge after bit 0 is driven sets tx_oe to 0 and tx_slot_n to 1.
- R6: Each transmit frame start captures tx_word, and the frame sends the word captured at the previous frame start. The first frame after reset sends all zeros.
- R7: After a receive frame start, falling edges 1 to 8 latch rx_din from MSB to LSB. In the cycle after the 8th falling edge, rx_word holds the new word and rx_valid is 1 for exactly that one cycle. rx_word changes at no other time.
- R8: A frame sync seen at a falling edge in the middle of a frame restarts both directions at that edge. The transmitter releases its output at once and resends from bit 7 of the newly loaded word, and the partial receive word is dropped with no rx_valid.
- R9: When share_bclk is 1, the receive side is clocked by tx_bclk and rx_bclk has no effect. When share_bclk is 0, only rx_bclk clocks the receive side.
- R10: A frame sync present at the 8th falling edge of a frame completes that frame and also starts the next one, so back-to-back frames run with no idle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial-side inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| share_bclk | input | 1 | 1: the receive side uses tx_bclk |
| tx_bclk | input | 1 | Transmit bit clock level |
| tx_fs | input | 1 | Transmit frame sync, one bit period wide |
| tx_word | input | WORD_W | Parallel word captured at each transmit frame start |
| tx_dout | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Output enable for the tri-state driver of tx_dout |
| tx_slot_n | output | 1 | Active-low slot indicator, low while transmitting |
| rx_bclk | input | 1 | Receive bit clock level |
| rx_fs | input | 1 | Receive frame sync, one bit period wide |
| rx_din | input | 1 | Serial receive data |
| rx_word | output | WORD_W | Last complete received word |
| rx_valid | output | 1 | Single-cycle strobe for a new rx_word |

## Verification
If the transmit bit counter or the armed flag is wrong, the fault appears on tx_oe and tx_dout within one bit period. The output opens on the wrong edge, stays open for too many or too few rising edges, or shows a shifted bit pattern. The bench therefore checks every bit of every slot. A stale holding register does not change any bit timing, but it sends the wrong frame's word, so the one-frame delay is checked across sequences of different words. A wrong receive count shows up as a missing, early or extra rx_valid at the 8th falling edge, so the bench counts strobes across aborted frames as well as across the back-to-back and clock-select cases.

// File: rtl/pcm_sf_pkg.sv
package pcm_sf_pkg;

   typedef enum logic [1:0] {
      TX_IDLE  = 2'd0,
      TX_ARMED = 2'd1,
      TX_SHIFT = 2'd2
   } tx_state_e;

   typedef struct packed {
      logic rise;
      logic fall;
   } bclk_edge_t;

endpackage

// File: rtl/pcm_sf_edge.sv
module pcm_sf_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   lvl_in,
   output pcm_sf_pkg::bclk_edge_t edge_o
);
   logic lvl_s;
   logic lvl_q;

   initial begin
      if (SYNC_STAGES < 0) $fatal(1, "SYNC_STAGES must not be negative");
   end

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl_s = lvl_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain, lvl_in};
         end
         assign lvl_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_s;
   end

   assign edge_o.rise = lvl_s & ~lvl_q;
   assign edge_o.fall = ~lvl_s & lvl_q;
endmodule

// File: rtl/pcm_sf_tx.sv
module pcm_sf_tx #(
   parameter int WORD_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  pcm_sf_pkg::bclk_edge_t bedge,
   input  logic                   fs,
   input  logic [WORD_W-1:0]      word_in,
   output logic                   dout,
   output logic                   oe
);
   import pcm_sf_pkg::*;

   localparam int CNT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W);

   tx_state_e         state;
   logic [CNT_W-1:0]  bit_cnt;
   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= TX_IDLE;
         bit_cnt <= '0;
         shreg   <= '0;
         hold    <= '0;
         dout    <= 1'b0;
         oe      <= 1'b0;
      end else if (bedge.fall) begin
         if (fs) begin
            shreg   <= hold;
            hold    <= word_in;
            bit_cnt <= '0;
            oe      <= 1'b0;
            state   <= TX_ARMED;
         end else if (state == TX_SHIFT && bit_cnt == LAST) begin
            oe    <= 1'b0;
            state <= TX_IDLE;
         end
      end else if (bedge.rise) begin
         if (state == TX_ARMED) begin
            oe      <= 1'b1;
            dout    <= shreg[WORD_W-1];
            shreg   <= {shreg[WORD_W-2:0], 1'b0};
            bit_cnt <= CNT_W'(1);
            state   <= TX_SHIFT;
         end else if (state == TX_SHIFT && bit_cnt != LAST) begin
            dout    <= shreg[WORD_W-1];
            shreg   <= {shreg[WORD_W-2:0], 1'b0};
            bit_cnt <= bit_cnt + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/pcm_sf_rx.sv
module pcm_sf_rx #(
   parameter int WORD_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  pcm_sf_pkg::bclk_edge_t bedge,
   input  logic                   fs,
   input  logic                   din,
   output logic [WORD_W-1:0]      word_out,
   output logic                   valid
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic              active;
   logic [CNT_W-1:0]  bit_cnt;
   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] next_sh;

   assign next_sh = {shreg[WORD_W-2:0], din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         bit_cnt  <= '0;
         shreg    <= '0;
         word_out <= '0;
         valid    <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (bedge.fall) begin
            if (active) begin
               shreg <= next_sh;
               if (bit_cnt == LAST) begin
                  word_out <= next_sh;
                  valid    <= 1'b1;
                  active   <= 1'b0;
               end else begin
                  bit_cnt <= bit_cnt + CNT_W'(1);
               end
            end
            if (fs) begin
               active  <= 1'b1;
               bit_cnt <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/pcm_sf_port.sv
module pcm_sf_port #(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              share_bclk,
   input  logic              tx_bclk,
   input  logic              tx_fs,
   input  logic [WORD_W-1:0] tx_word,
   output logic              tx_dout,
   output logic              tx_oe,
   output logic              tx_slot_n,
   input  logic              rx_bclk,
   input  logic              rx_fs,
   input  logic              rx_din,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid
);
   import pcm_sf_pkg::*;

   initial begin
      if (WORD_W < 2) $fatal(1, "WORD_W must be at least 2");
   end

   bclk_edge_t tx_edge;
   bclk_edge_t rx_edge;
   logic       rx_bclk_sel;

   assign rx_bclk_sel = share_bclk ? tx_bclk : rx_bclk;

   pcm_sf_edge #(.SYNC_STAGES(SYNC_STAGES)) u_tx_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_in (tx_bclk),
      .edge_o (tx_edge)
   );

   pcm_sf_edge #(.SYNC_STAGES(SYNC_STAGES)) u_rx_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_in (rx_bclk_sel),
      .edge_o (rx_edge)
   );

   logic tx_fs_d;
   logic rx_fs_d;
   logic rx_din_d;

   generate
      if (SYNC_STAGES == 0) begin : g_nodly
         assign tx_fs_d  = tx_fs;
         assign rx_fs_d  = rx_fs;
         assign rx_din_d = rx_din;
      end else begin : g_dly
         logic [SYNC_STAGES-1:0] c_tfs, c_rfs, c_rd;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               c_tfs <= '0;
               c_rfs <= '0;
               c_rd  <= '0;
            end else begin
               c_tfs <= {c_tfs, tx_fs};
               c_rfs <= {c_rfs, rx_fs};
               c_rd  <= {c_rd, rx_din};
            end
         end
         assign tx_fs_d  = c_tfs[SYNC_STAGES-1];
         assign rx_fs_d  = c_rfs[SYNC_STAGES-1];
         assign rx_din_d = c_rd[SYNC_STAGES-1];
      end
   endgenerate

   pcm_sf_tx #(.WORD_W(WORD_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .bedge   (tx_edge),
      .fs      (tx_fs_d),
      .word_in (tx_word),
      .dout    (tx_dout),
      .oe      (tx_oe)
   );

   assign tx_slot_n = ~tx_oe;

   pcm_sf_rx #(.WORD_W(WORD_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .bedge    (rx_edge),
      .fs       (rx_fs_d),
      .din      (rx_din_d),
      .word_out (rx_word),
      .valid    (rx_valid)
   );
endmodule

// File: rtl/pcm_sf_port_chk.sv
module pcm_sf_port_chk #(
   parameter int WORD_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              share_bclk,
   input logic              tx_bclk,
   input logic              rx_bclk,
   input logic              tx_dout,
   input logic              tx_oe,
   input logic [WORD_W-1:0] rx_word,
   input logic              rx_valid
);
   logic rxc;
   assign rxc = share_bclk ? tx_bclk : rx_bclk;

   AST_OE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_oe) |-> ($past(tx_bclk) && !$past(tx_bclk, 2))); // R3

   AST_DOUT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tx_dout) |-> ($past(tx_bclk) && !$past(tx_bclk, 2))); // R4

   AST_OE_OFF_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_oe) |-> (!$past(tx_bclk) && $past(tx_bclk, 2))); // R5

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid); // R7

   AST_VALID_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_valid) |-> (!$past(rxc) && $past(rxc, 2))); // R7

   AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable(rx_word)); // R7
endmodule

bind pcm_sf_port pcm_sf_port_chk #(.WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .share_bclk (share_bclk),
   .tx_bclk    (tx_bclk),
   .rx_bclk    (rx_bclk),
   .tx_dout    (tx_dout),
   .tx_oe      (tx_oe),
   .rx_word    (rx_word),
   .rx_valid   (rx_valid)
);

// File: tb/pcm_sf_port_tb.sv
module pcm_sf_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       share = 1'b0;
   logic       bclk = 1'b0;
   logic       rxb = 1'b0;
   logic       tfs = 1'b0;
   logic       rfs = 1'b0;
   logic       din = 1'b0;
   logic [7:0] tword = 8'h00;
   logic       tx_dout, tx_oe, tx_slot_n, rx_valid;
   logic [7:0] rx_word;

   int checks = 0;
   int fails = 0;
   int vcount = 0;
   bit rx_follow = 1'b1;
   logic [7:0] exp_prev = 8'h00;
   logic [7:0] exp_tx = 8'h00;
   logic [7:0] last_rx = 8'h00;

   pcm_sf_port u_dut (
      .clk(clk), .rst_n(rst_n), .share_bclk(share),
      .tx_bclk(bclk), .tx_fs(tfs), .tx_word(tword),
      .tx_dout(tx_dout), .tx_oe(tx_oe), .tx_slot_n(tx_slot_n),
      .rx_bclk(rxb), .rx_fs(rfs), .rx_din(din),
      .rx_word(rx_word), .rx_valid(rx_valid)
   );

   always #2 clk = ~clk;

   always @(posedge clk) if (rst_n && rx_valid) vcount++;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic rise(input bit fs, input bit d);
      @(negedge clk);
      bclk = 1'b1; rxb = rx_follow; tfs = fs; rfs = fs; din = d;
      @(posedge clk); #1;
   endtask

   task automatic fall();
      @(negedge clk);
      if (tfs) begin exp_tx = exp_prev; exp_prev = tword; end
      bclk = 1'b0; rxb = 1'b0;
      @(posedge clk); #1;
   endtask

   task automatic run_frame(input logic [7:0] present, input logic [7:0] rxw,
                            input int nbits, input bit do_start, input bit fs_last,
                            input logic [7:0] next_present, input string start_tag,
                            input string dtag, input bit expect_rx);
      if (do_start) begin
         tword = present;
         rise(1'b1, 1'b0);
         @(posedge clk);
         fall();
         chk(start_tag, tx_oe, 0);
         @(posedge clk);
      end
      for (int i = 0; i < nbits; i++) begin
         if (i == 7 && fs_last) tword = next_present;
         rise(i == 7 && fs_last, rxw[7-i]);
         chk(i == 0 ? "R3" : dtag, tx_dout, exp_tx[7-i]);
         chk("R3", tx_oe, 1);
         chk("R3", tx_slot_n, 0);
         @(posedge clk);
         fall();
         if (i == 7) begin
            chk("R5", tx_oe, 0);
            chk("R5", tx_slot_n, 1);
            if (expect_rx) begin
               chk("R7", rx_valid, 1);
               chk("R7", rx_word, rxw);
               last_rx = rxw;
            end else begin
               chk("R9", rx_valid, 0);
               chk("R9", rx_word, last_rx);
            end
            @(posedge clk); #1;
            chk("R7", rx_valid, 0);
         end else begin
            chk(nbits < 8 ? "R8" : "R7", rx_valid, 0);
            @(posedge clk);
         end
      end
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int v;
      bit aborted;
      void'($urandom(32'h5eed));
      repeat (4) @(posedge clk);
      #1;
      chk("R1", tx_oe, 0);
      chk("R1", tx_slot_n, 1);
      chk("R1", rx_valid, 0);
      chk("R1", rx_word, 0);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // R6: first frame sends zeros, second sends first word
      run_frame(8'hA5, 8'h3C, 8, 1, 0, 8'h00, "R5", "R6", 1);
      run_frame(8'h5A, 8'hC3, 8, 1, 0, 8'h00, "R5", "R6", 1);

      // R2: frame sync pulse confined to the high phase
      v = vcount;
      tword = 8'hEE;
      rise(1'b1, 1'b0);
      @(negedge clk); tfs = 1'b0; rfs = 1'b0;
      @(posedge clk);
      fall();
      chk("R2", tx_oe, 0);
      @(posedge clk);
      rise(1'b0, 1'b0);
      chk("R2", tx_oe, 0);
      chk("R2", tx_slot_n, 1);
      @(posedge clk);
      fall(); @(posedge clk);
      chk("R2", vcount, v);

      // R8: abort after 3 bits, restart
      v = vcount;
      run_frame(8'h81, 8'hFF, 3, 1, 0, 8'h00, "R5", "R4", 1);
      run_frame(8'h7E, 8'h96, 8, 1, 0, 8'h00, "R8", "R8", 1);
      chk("R8", vcount, v + 1);

      // R10: back-to-back frames
      run_frame(8'h11, 8'h22, 8, 1, 1, 8'h33, "R5", "R4", 1);
      run_frame(8'h33, 8'h44, 8, 0, 0, 8'h00, "R10", "R10", 1);
      chk("R10", exp_tx, 8'h11);

      // R9: receive clock selection
      rx_follow = 1'b0; share = 1'b0;
      v = vcount;
      run_frame(8'h55, 8'hA9, 8, 1, 0, 8'h00, "R5", "R4", 0);
      chk("R9", vcount, v);
      share = 1'b1;
      run_frame(8'hC6, 8'h5B, 8, 1, 0, 8'h00, "R5", "R4", 1);
      chk("R9", vcount, v + 1);
      share = 1'b0; rx_follow = 1'b1;

      // random frames with occasional aborts
      aborted = 1'b0;
      for (int k = 0; k < 24; k++) begin
         int nb;
         nb = (($urandom % 4) == 0) ? 1 + int'($urandom % 7) : 8;
         v = vcount;
         run_frame(8'($urandom), 8'($urandom), nb, 1, 0, 8'h00,
                   aborted ? "R8" : "R5", "R4", 1);
         chk(nb < 8 ? "R8" : "R7", vcount, nb < 8 ? v : v + 1);
         aborted = (nb < 8);
      end

      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule